// File: doc/BRIEF.md
# Serial Configuration Shift Chain with Shadow Readback

This block holds the static settings of a multichannel sampling and digitizing front end. The settings are three 6-bit reference DAC codes (ramp start voltage, difference amplifier reference and ramp current), a bit that selects the difference amplifier path for conversion, and two analog probe multiplexer groups. Each probe group has an output enable, a 5-bit channel address and a pull-down control.

A 33-bit shift chain takes configuration data one bit per enabled clock. The first bit in travels to the far end of the chain. A latch strobe copies the whole chain into a shadow register, and the decoded outputs are driven from that shadow register. Shifting therefore never disturbs the live settings.

For verification, a capture strobe loads the shadow value back into the chain in parallel. The settings then leave on the serial output in the same order in which they were loaded. A controller can compare them with what it sent, and it can shift a new string in during the same pass.

Top module: `cfg_serial_chain`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the shadow register, the chain, the serial output and every decoded output are zero, so both probe groups are disabled.
- R2: On each clock with shift enable high and capture low, the chain moves one place toward the serial output and takes the serial input at its near end. After 33 such clocks, the first bit shifted in sits at the serial output.
- R3: Counting the string positions from 1 in arrival order: position 1 drives the probe B output enable, positions 2 to 6 drive probe B address bits 0 to 4, and position 7 drives the difference path select.
- R4: Positions 8 to 13 drive the ramp start DAC code bits 0 to 5. Positions 14 to 19 drive the difference reference DAC code bits 0 to 5. Positions 20 to 25 drive the ramp current DAC code bits 0 to 5.
- R5: Position 26 drives the probe B pull-down and position 27 drives the probe A pull-down. Position 28 drives the probe A output enable, and positions 29 to 33 drive probe A address bits 0 to 4.
- R6: The decoded outputs change only on a clock with the latch strobe high. Shifts and captures without a latch strobe leave them unchanged.
- R7: A latch strobe stores the chain contents as they are before that clock edge, including when shift enable is high on the same clock.
- R8: A capture strobe loads the shadow value into the chain, which puts position 1 on the serial output after that edge. The next 32 shift clocks present positions 2 to 33 in order. A capture wins over a shift on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Shift the chain by one place |
| sdi | input | 1 | Serial data input |
| latch_stb | input | 1 | Copy the chain into the shadow register |
| capture_stb | input | 1 | Load the shadow register into the chain for readback |
| sdo | output | 1 | Serial output, far end of the chain |
| vref_code | output | 6 | Ramp start DAC code |
| corr_code | output | 6 | Difference reference DAC code |
| iref_code | output | 6 | Ramp current DAC code |
| diff_sel | output | 1 | Difference amplifier path select |
| probe_a_oe | output | 1 | Probe A output enable |
| probe_a_addr | output | 5 | Probe A channel address |
| probe_a_pd | output | 1 | Probe A pull-down |
| probe_b_oe | output | 1 | Probe B output enable |
| probe_b_addr | output | 5 | Probe B channel address |
| probe_b_pd | output | 1 | Probe B pull-down |

## Verification
The bench builds the block with its default widths: 6-bit DAC codes and 5-bit addresses, which give a 33-bit chain. At these values, a single set bit walked to the first, seventh, eighth, 26th and last positions touches each field boundary of the nonuniform order. Seeded random strings then cover every field with mixed patterns. Each string is latched and then read back through the capture path, and the bench also drives a latch with a shift and a capture with a shift on the same clock to check the tie-break rules.

// File: rtl/cfg_serial_chain.sv
module cfg_serial_chain #(
  parameter int DAC_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdi,
  input  logic              latch_stb,
  input  logic              capture_stb,
  output logic              sdo,
  output logic [DAC_W-1:0]  vref_code,
  output logic [DAC_W-1:0]  corr_code,
  output logic [DAC_W-1:0]  iref_code,
  output logic              diff_sel,
  output logic              probe_a_oe,
  output logic [ADDR_W-1:0] probe_a_addr,
  output logic              probe_a_pd,
  output logic              probe_b_oe,
  output logic [ADDR_W-1:0] probe_b_addr,
  output logic              probe_b_pd
);

  localparam int N        = 2*ADDR_W + 3*DAC_W + 5;
  localparam int P_B_OE   = N - 1;
  localparam int P_B_ADDR = P_B_OE - 1;
  localparam int P_SEL    = P_B_ADDR - ADDR_W;
  localparam int P_VREF   = P_SEL - 1;
  localparam int P_CORR   = P_VREF - DAC_W;
  localparam int P_IREF   = P_CORR - DAC_W;
  localparam int P_B_PD   = P_IREF - DAC_W;
  localparam int P_A_PD   = P_B_PD - 1;
  localparam int P_A_OE   = P_A_PD - 1;
  localparam int P_A_ADDR = P_A_OE - 1;

  logic [N-1:0] chain;
  logic [N-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      shadow <= '0;
    end else begin
      if (capture_stb)   chain <= shadow;
      else if (shift_en) chain <= {chain[N-2:0], sdi};
      if (latch_stb)     shadow <= chain;
    end
  end

  assign sdo        = chain[N-1];
  assign probe_b_oe = shadow[P_B_OE];
  assign diff_sel   = shadow[P_SEL];
  assign probe_b_pd = shadow[P_B_PD];
  assign probe_a_pd = shadow[P_A_PD];
  assign probe_a_oe = shadow[P_A_OE];

  for (genvar j = 0; j < DAC_W; j++) begin : g_dac
    assign vref_code[j] = shadow[P_VREF - j];
    assign corr_code[j] = shadow[P_CORR - j];
    assign iref_code[j] = shadow[P_IREF - j];
  end

  for (genvar j = 0; j < ADDR_W; j++) begin : g_addr
    assign probe_b_addr[j] = shadow[P_B_ADDR - j];
    assign probe_a_addr[j] = shadow[P_A_ADDR - j];
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (shadow == '0 && chain == '0 && !probe_a_oe && !probe_b_oe));

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_stb) |=> chain == {$past(chain[N-2:0]), $past(sdi)});

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(shadow));

  assert_latch_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> shadow == $past(chain));

  assert_capture_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_stb |=> (chain == $past(shadow) && sdo == $past(shadow[N-1])));

endmodule

// File: tb/cfg_serial_chain_tb.sv
module cfg_serial_chain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 33;

  logic clk = 0, rst_n = 0, shift_en = 0, sdi = 0, latch_stb = 0, capture_stb = 0;
  logic sdo, diff_sel, probe_a_oe, probe_a_pd, probe_b_oe, probe_b_pd;
  logic [5:0] vref_code, corr_code, iref_code;
  logic [4:0] probe_a_addr, probe_b_addr;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_chain dut_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi),
    .latch_stb(latch_stb), .capture_stb(capture_stb), .sdo(sdo),
    .vref_code(vref_code), .corr_code(corr_code), .iref_code(iref_code),
    .diff_sel(diff_sel), .probe_a_oe(probe_a_oe), .probe_a_addr(probe_a_addr),
    .probe_a_pd(probe_a_pd), .probe_b_oe(probe_b_oe), .probe_b_addr(probe_b_addr),
    .probe_b_pd(probe_b_pd));

  // Outputs repacked into arrival order: bit k-1 holds position k.
  function automatic logic [N-1:0] observed();
    logic [N-1:0] o;
    o[0] = probe_b_oe;
    for (int j = 0; j < 5; j++) o[1+j] = probe_b_addr[j];
    o[6] = diff_sel;
    for (int j = 0; j < 6; j++) begin
      o[7+j]  = vref_code[j];
      o[13+j] = corr_code[j];
      o[19+j] = iref_code[j];
    end
    o[25] = probe_b_pd;
    o[26] = probe_a_pd;
    o[27] = probe_a_oe;
    for (int j = 0; j < 5; j++) o[28+j] = probe_a_addr[j];
    return o;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic sh, logic d, logic la, logic ca);
    @(negedge clk);
    shift_en = sh; sdi = d; latch_stb = la; capture_stb = ca;
    @(posedge clk); #1;
    shift_en = 0; latch_stb = 0; capture_stb = 0;
  endtask

  task automatic send(logic [N-1:0] w);
    for (int k = 0; k < N; k++) step(1, w[k], 0, 0);
  endtask

  task automatic check_fields(logic [N-1:0] w);
    logic [N-1:0] o;
    o = observed();
    chk("R3 order 1-7", 64'(o[6:0]), 64'(w[6:0]));
    chk("R4 DAC codes 8-25", 64'(o[24:7]), 64'(w[24:7]));
    chk("R5 order 26-33", 64'(o[32:25]), 64'(w[32:25]));
  endtask

  task automatic readback(logic [N-1:0] w);
    logic [N-1:0] got;
    step(0, 0, 0, 1);
    for (int k = 0; k < N; k++) begin
      got[k] = sdo;
      if (k < N-1) step(1, 0, 0, 0);
    end
    chk("R8 readback order", 64'(got), 64'(w));
  endtask

  task automatic full_cycle(logic [N-1:0] w);
    logic [N-1:0] prev;
    prev = observed();
    send(w);
    chk("R6 outputs held during shift", 64'(observed()), 64'(prev));
    chk("R2 first bit at sdo after 33 shifts", 64'(sdo), 64'(w[0]));
    step(0, 0, 1, 0);
    check_fields(w);
    readback(w);
    chk("R6 outputs held over readback", 64'(observed()), 64'(w));
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] w;
    void'($urandom(32'h1234abcd));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outputs zero in reset", 64'(observed()), 64'd0);
    chk("R1 sdo zero in reset", 64'(sdo), 64'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 outputs zero after reset", 64'(observed()), 64'd0);

    full_cycle({N{1'b1}});
    full_cycle('0);
    foreach (w[k]) begin
      if (k == 0 || k == 6 || k == 7 || k == 25 || k == 32) full_cycle(N'(1) << k);
    end
    for (int r = 0; r < 6; r++) begin
      w = N'({$urandom, $urandom});
      full_cycle(w);
    end

    // R7: latch with shift on the same clock keeps the pre-shift chain
    w = N'({$urandom, $urandom}) | N'(1);
    send(w);
    step(1, 1, 1, 0);
    check_fields(w);
    chk("R7 latch ignores concurrent shift", 64'(observed()), 64'(w));

    // R8: capture beats shift on the same clock
    step(1, 0, 0, 1);
    chk("R8 capture wins over shift", 64'(sdo), 64'(w[0]));
    step(1, 0, 0, 0);
    chk("R8 second position after one shift", 64'(sdo), 64'(w[1]));

    // R1: reset reasserted clears latched state
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    chk("R1 reset clears shadow", 64'(observed()), 64'd0);
    chk("R1 reset clears chain", 64'(sdo), 64'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end
endmodule